// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Controller

This block is the command-acceptance core that sits behind the serial front end of a flash device. It receives one decoded command per cycle, together with the level of the write-protect pin and a strap that selects the one-time-programmable mode. For each command it decides whether the command is accepted. It then updates an 8-bit status image that holds the busy flag, the write-enable latch, four block-protect bits, a pin-disable bit and a status-protect bit.

Status writes, programs and erases start an internal cycle. The block models that cycle with a down-counter loaded from a per-operation parameter, and the busy flag stays set until the counter expires. A sleep command parks the block so that only a wake command is honoured.

In one-time-programmable mode the top status bit reports a lock flag instead of the status-protect bit. The lock flag can only ever be set. Once it is set, it refuses program and erase.

Top module: `fsr_guard`

## Requirements
- R1: After a synchronous reset, `status` is 8'h00, `cmd_accept` is 0 and `sleeping` is 0. The status layout is: bit 0 busy, bit 1 write-enable latch, bits 5:2 block-protect 0..3, bit 6 pin-disable, bit 7 status-protect (or lock in one-time mode).
- R2: The command codes are 0 read-status, 1 write-enable, 2 write-status, 3 program, 4 erase, 5 sleep, 6 wake and 7 reserved. `cmd_accept` pulses in the cycle after an accepted command and stays 0 otherwise. Write-enable sets the latch. Read-status and reserved change nothing, and reserved is never accepted.
- R3: Write-status, program and erase with the latch clear are not accepted and change nothing. Busy rises only on a command that found the latch set.
- R4: An accepted write-status copies `cmd_field` into the status. Field bits 3:0 go to block-protect 3..0, bit 4 to pin-disable and bit 5 to status-protect or lock. Busy and the latch read 1 in the following cycle.
- R5: Busy stays high for exactly T_WRSR, T_PROG or T_ERASE cycles for the operation that started it. Busy and the latch clear in the same cycle.
- R6: While busy, only read-status is accepted. All other commands have no effect.
- R7: Outside one-time mode, when status-protect is 1, `wp_n` is 0 and pin-disable is 0, a write-status is refused: bits 7:2 are kept and the latch clears. When pin-disable is 1, `wp_n` is ignored.
- R8: An accepted sleep sets `sleeping`. While sleeping, every command except wake is refused and leaves `status` unchanged. Wake clears `sleeping`, and wake is refused when not sleeping.
- R9: With `otp_mode` high, bit 7 shows the lock flag. Write-status can set the lock but never clear it. While the lock is set, program and erase are refused and clear the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_field | input | 6 | Data for a status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| otp_mode | input | 1 | One-time-programmable mode strap |
| cmd_accept | output | 1 | The command of the previous cycle was accepted |
| status | output | 8 | Status image |
| sleeping | output | 1 | Deep power-down state |

## Verification
A wrong latch or busy state shows up on `status` one cycle after the command that caused it. If the state instead blocks a later command, it shows up as a missing `cmd_accept` pulse. A miscounted busy window moves the falling edge of bit 0 by at least one cycle, and the bench measures that edge exactly for all three durations. Protection faults are exposed by writes that must leave bits 7:2 untouched, and a lock that clears wrongly shows on bit 7 after the next write.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    OP_RDSR  = 3'd0,
    OP_WREN  = 3'd1,
    OP_WRSR  = 3'd2,
    OP_PROG  = 3'd3,
    OP_ERASE = 3'd4,
    OP_SLEEP = 3'd5,
    OP_WAKE  = 3'd6,
    OP_RSVD  = 3'd7
  } fsr_op_e;

  localparam int BP_W   = 4;
  localparam int STAT_W = 8;
  localparam int FLD_W  = BP_W + 2;

  // status bit positions
  localparam int S_WIP   = 0;
  localparam int S_WEL   = 1;
  localparam int S_BP_LO = 2;
  localparam int S_PDIS  = 6;
  localparam int S_PROT  = 7;
endpackage

// File: rtl/fsr_busy_timer.sv
module fsr_busy_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start_i)       cnt_q <= load_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(1)) && !start_i;
endmodule

// File: rtl/fsr_cmd_gate.sv
module fsr_cmd_gate
  import fsr_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int T_WRSR  = 4,
  parameter int T_PROG  = 6,
  parameter int T_ERASE = 9
) (
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic             wip_i,
  input  logic             wel_i,
  input  logic             dpd_i,
  input  logic             prot_i,
  input  logic             pdis_i,
  input  logic             lock_i,
  input  logic             otp_i,
  input  logic             wp_n_i,
  output logic             accept_o,
  output logic             set_wel_o,
  output logic             drop_wel_o,
  output logic             start_o,
  output logic             write_sr_o,
  output logic             enter_dpd_o,
  output logic             leave_dpd_o,
  output logic [CNT_W-1:0] load_o
);
  logic pin_locked;
  logic otp_refuse;

  // hardware protection only applies outside one-time mode
  assign pin_locked = prot_i && !wp_n_i && !pdis_i && !otp_i;
  assign otp_refuse = otp_i && lock_i;

  always_comb begin
    accept_o    = 1'b0;
    set_wel_o   = 1'b0;
    drop_wel_o  = 1'b0;
    start_o     = 1'b0;
    write_sr_o  = 1'b0;
    enter_dpd_o = 1'b0;
    leave_dpd_o = 1'b0;
    load_o      = '0;
    if (cmd_valid_i) begin
      if (dpd_i) begin
        if (cmd_op_i == OP_WAKE) begin
          accept_o    = 1'b1;
          leave_dpd_o = 1'b1;
        end
      end else if (wip_i) begin
        if (cmd_op_i == OP_RDSR) accept_o = 1'b1;
      end else begin
        case (cmd_op_i)
          OP_RDSR: accept_o = 1'b1;
          OP_WREN: begin
            accept_o  = 1'b1;
            set_wel_o = 1'b1;
          end
          OP_WRSR: begin
            if (wel_i) begin
              if (pin_locked) begin
                drop_wel_o = 1'b1;
              end else begin
                accept_o   = 1'b1;
                start_o    = 1'b1;
                write_sr_o = 1'b1;
                load_o     = CNT_W'(T_WRSR);
              end
            end
          end
          OP_PROG, OP_ERASE: begin
            if (wel_i) begin
              if (otp_refuse) begin
                drop_wel_o = 1'b1;
              end else begin
                accept_o = 1'b1;
                start_o  = 1'b1;
                load_o   = (cmd_op_i == OP_PROG) ? CNT_W'(T_PROG) : CNT_W'(T_ERASE);
              end
            end
          end
          OP_SLEEP: begin
            accept_o    = 1'b1;
            enter_dpd_o = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fsr_guard.sv
module fsr_guard
  import fsr_pkg::*;
#(
  parameter int T_WRSR  = 4,
  parameter int T_PROG  = 6,
  parameter int T_ERASE = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [FLD_W-1:0]     cmd_field,
  input  logic                 wp_n,
  input  logic                 otp_mode,
  output logic                 cmd_accept,
  output logic [STAT_W-1:0]    status,
  output logic                 sleeping
);
  localparam int T_MAX1 = (T_WRSR > T_PROG) ? T_WRSR : T_PROG;
  localparam int T_MAX  = (T_MAX1 > T_ERASE) ? T_MAX1 : T_ERASE;
  localparam int CNT_W  = $clog2(T_MAX + 1);

  logic            wip_q, wel_q, pdis_q, prot_q, lock_q, dpd_q, acc_q;
  logic [BP_W-1:0] bp_q;

  logic             g_accept, g_set_wel, g_drop_wel, g_start, g_write;
  logic             g_enter, g_leave, t_last;
  logic [CNT_W-1:0] g_load;

  fsr_cmd_gate #(
    .CNT_W(CNT_W), .T_WRSR(T_WRSR), .T_PROG(T_PROG), .T_ERASE(T_ERASE)
  ) gate_i (
    .cmd_valid_i (cmd_valid),
    .cmd_op_i    (cmd_op),
    .wip_i       (wip_q),
    .wel_i       (wel_q),
    .dpd_i       (dpd_q),
    .prot_i      (prot_q),
    .pdis_i      (pdis_q),
    .lock_i      (lock_q),
    .otp_i       (otp_mode),
    .wp_n_i      (wp_n),
    .accept_o    (g_accept),
    .set_wel_o   (g_set_wel),
    .drop_wel_o  (g_drop_wel),
    .start_o     (g_start),
    .write_sr_o  (g_write),
    .enter_dpd_o (g_enter),
    .leave_dpd_o (g_leave),
    .load_o      (g_load)
  );

  fsr_busy_timer #(.CNT_W(CNT_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (g_start),
    .load_i  (g_load),
    .last_o  (t_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wip_q  <= 1'b0;
      wel_q  <= 1'b0;
      bp_q   <= '0;
      pdis_q <= 1'b0;
      prot_q <= 1'b0;
      lock_q <= 1'b0;
      dpd_q  <= 1'b0;
      acc_q  <= 1'b0;
    end else begin
      acc_q <= g_accept;
      if (g_start)     wip_q <= 1'b1;
      else if (t_last) wip_q <= 1'b0;
      if (g_set_wel)                  wel_q <= 1'b1;
      else if (g_drop_wel || t_last)  wel_q <= 1'b0;
      if (g_write) begin
        bp_q   <= cmd_field[BP_W-1:0];
        pdis_q <= cmd_field[BP_W];
        if (otp_mode) lock_q <= lock_q | cmd_field[BP_W+1];
        else          prot_q <= cmd_field[BP_W+1];
      end
      if (g_enter)      dpd_q <= 1'b1;
      else if (g_leave) dpd_q <= 1'b0;
    end
  end

  assign cmd_accept = acc_q;
  assign sleeping   = dpd_q;
  assign status     = {otp_mode ? lock_q : prot_q, pdis_q, bp_q, wel_q, wip_q};
endmodule

// File: rtl/fsr_guard_chk.sv
module fsr_guard_chk
  import fsr_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_op,
  input logic [FLD_W-1:0]     cmd_field,
  input logic                 wp_n,
  input logic                 otp_mode,
  input logic                 cmd_accept,
  input logic [STAT_W-1:0]    status,
  input logic                 sleeping
);
  logic unused_fld;
  assign unused_fld = ^cmd_field;

  AST_ACCEPT_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !cmd_accept); // R2
  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    $rose(status[S_WIP]) |-> $past(status[S_WEL])); // R3
  AST_WEL_DROPS_WITH_WIP: assert property (@(posedge clk) disable iff (rst)
    $fell(status[S_WIP]) |-> !status[S_WEL]); // R5
  AST_BUSY_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && status[S_WIP] && cmd_op != OP_RDSR) |=> !cmd_accept); // R6
  AST_PIN_PROTECT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_WRSR && !otp_mode && status[S_PROT] &&
     !status[S_PDIS] && !wp_n) |=> $stable(status[7:2])); // R7
  AST_SLEEP_GATE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && sleeping && cmd_op != OP_WAKE) |=> (!cmd_accept && $stable(status))); // R8
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (otp_mode && status[S_PROT]) |=> (status[S_PROT] || !otp_mode)); // R9
endmodule

bind fsr_guard fsr_guard_chk chk_i (.*);

// File: tb/fsr_guard_tb.sv
module fsr_guard_tb_top;
  localparam int TW = 4, TP = 6, TE = 9;
  localparam logic [2:0] RD = 3'd0, WE = 3'd1, WS = 3'd2, PG = 3'd3,
                         ER = 3'd4, SL = 3'd5, WK = 3'd6, RS = 3'd7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [5:0] cmd_field = 6'd0;
  logic       wp_n = 1'b1;
  logic       otp_mode = 1'b0;
  logic       cmd_accept, sleeping;
  logic [7:0] status;

  int    n_chk = 0, n_fail = 0;
  string phase = "R1";
  bit    done = 0;

  always #5 clk = ~clk;

  fsr_guard #(.T_WRSR(TW), .T_PROG(TP), .T_ERASE(TE)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_field(cmd_field), .wp_n(wp_n), .otp_mode(otp_mode),
    .cmd_accept(cmd_accept), .status(status), .sleeping(sleeping));

  // behavioural reference model
  int       m_cnt = 0;
  bit       m_wel, m_pdis, m_prot, m_lock, m_dpd, m_acc;
  bit [3:0] m_bp;

  always @(posedge clk) begin
    bit busy, started;
    if (rst) begin
      m_cnt = 0; m_wel = 0; m_pdis = 0; m_prot = 0; m_lock = 0;
      m_dpd = 0; m_acc = 0; m_bp = 0;
    end else begin
      busy = (m_cnt > 0); started = 0; m_acc = 0;
      if (cmd_valid) begin
        if (m_dpd) begin
          if (cmd_op == WK) begin m_acc = 1; m_dpd = 0; end
        end else if (busy) begin
          m_acc = (cmd_op == RD);
        end else if (cmd_op == RD) m_acc = 1;
        else if (cmd_op == WE) begin m_acc = 1; m_wel = 1; end
        else if (cmd_op == SL) begin m_acc = 1; m_dpd = 1; end
        else if (cmd_op == WS && m_wel) begin
          if (m_prot && !wp_n && !m_pdis && !otp_mode) m_wel = 0;
          else begin
            m_acc = 1; started = 1; m_cnt = TW;
            m_bp = cmd_field[3:0]; m_pdis = cmd_field[4];
            if (otp_mode) m_lock = m_lock || cmd_field[5];
            else m_prot = cmd_field[5];
          end
        end else if ((cmd_op == PG || cmd_op == ER) && m_wel) begin
          if (otp_mode && m_lock) m_wel = 0;
          else begin
            m_acc = 1; started = 1; m_cnt = (cmd_op == PG) ? TP : TE;
          end
        end
      end
      if (!started && m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_wel = 0;
      end
    end
  end

  function automatic logic [7:0] m_status();
    return {otp_mode ? m_lock : m_prot, m_pdis, m_bp, m_wel, (m_cnt > 0)};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(phase, "model status", status, m_status());
      check(phase, "model accept", cmd_accept, m_acc);
      check(phase, "model sleeping", sleeping, m_dpd);
    end
  end

  task automatic issue(input logic [2:0] op, input logic [5:0] f);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_field = f;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic measure(input string req, input int exp);
    int n = 0;
    while (status[0] && n < 100) begin n++; @(negedge clk); end
    check(req, "busy length", n, exp);
    check(req, "latch after busy", status[1], 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "reset status", status, 8'h00);
    check("R1", "reset accept", cmd_accept, 0);
    check("R1", "reset sleeping", sleeping, 0);

    phase = "R2";
    issue(RD, 0); check("R2", "read accepted", cmd_accept, 1);
    issue(RS, 6'h3F); check("R2", "reserved refused", cmd_accept, 0);
    check("R2", "reserved no effect", status, 8'h00);

    phase = "R3";
    issue(WS, 6'h3F); check("R3", "write no latch", cmd_accept, 0);
    issue(PG, 0); check("R3", "program no latch", cmd_accept, 0);
    issue(ER, 0); check("R3", "erase no latch", status, 8'h00);

    phase = "R4";
    issue(WE, 0); check("R2", "latch set", status, 8'h02);
    issue(WS, 6'b10_1111); check("R4", "write accepted", cmd_accept, 1);
    check("R4", "status image", status, 8'hBF);
    measure("R5", TW); check("R4", "after write", status, 8'hBC);

    phase = "R7";
    wp_n = 1'b0;
    issue(WE, 0); issue(WS, 6'h00);
    check("R7", "protected write refused", cmd_accept, 0);
    check("R7", "bits kept, latch cleared", status, 8'hBC);
    wp_n = 1'b1;
    issue(WE, 0); issue(WS, 6'b11_0000); measure("R5", TW);
    check("R7", "pin-disable set", status, 8'hC0);
    wp_n = 1'b0;
    issue(WE, 0); issue(WS, 6'b10_0101);
    check("R7", "pin ignored write", cmd_accept, 1);
    measure("R5", TW); check("R7", "status", status, 8'h94);
    issue(WE, 0); issue(WS, 6'h00);
    check("R7", "protected again", status, 8'h94);
    wp_n = 1'b1;
    issue(WE, 0); issue(WS, 6'h00); measure("R5", TW);
    check("R7", "cleared", status, 8'h00);

    phase = "R5";
    issue(WE, 0); issue(PG, 0); check("R5", "program accepted", cmd_accept, 1);
    measure("R5", TP);
    issue(WE, 0); issue(ER, 0); measure("R5", TE);

    phase = "R6";
    issue(WE, 0); issue(ER, 0);
    issue(WE, 0); check("R6", "wren while busy", cmd_accept, 0);
    issue(SL, 0); check("R6", "sleep while busy", cmd_accept, 0);
    issue(RD, 0); check("R6", "read while busy", cmd_accept, 1);
    issue(WS, 6'h3F); check("R6", "write while busy", cmd_accept, 0);
    while (status[0]) @(negedge clk);
    check("R6", "status after busy", status, 8'h00);
    check("R6", "not sleeping", sleeping, 0);

    phase = "R8";
    issue(WK, 0); check("R8", "wake when awake", cmd_accept, 0);
    issue(SL, 0); check("R8", "sleep accepted", cmd_accept, 1);
    check("R8", "sleeping", sleeping, 1);
    issue(RD, 0); check("R8", "read while asleep", cmd_accept, 0);
    issue(WE, 0); check("R8", "wren while asleep", status, 8'h00);
    issue(WK, 0); check("R8", "wake accepted", cmd_accept, 1);
    check("R8", "awake", sleeping, 0);

    phase = "R9";
    otp_mode = 1'b1;
    issue(WE, 0); issue(WS, 6'b10_0000); measure("R5", TW);
    check("R9", "lock set", status, 8'h80);
    issue(WE, 0); issue(WS, 6'h00); measure("R5", TW);
    check("R9", "lock sticks", status, 8'h80);
    issue(WE, 0); issue(PG, 0); check("R9", "program refused", cmd_accept, 0);
    check("R9", "latch cleared", status, 8'h80);
    issue(WE, 0); issue(ER, 0); check("R9", "erase refused", cmd_accept, 0);
    @(negedge clk); otp_mode = 1'b0;
    @(negedge clk); check("R9", "bit7 back to protect", status, 8'h00);
    issue(WE, 0); issue(PG, 0); check("R9", "program outside otp", cmd_accept, 1);
    measure("R5", TP);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule